// File: doc/BRIEF.md
# Prefetch Stall Chip-Select Timeout

This block decides when a memory-mapped serial flash read path should give up an open read burst. The read path prefetches flash data into a FIFO ahead of the requester. When that FIFO fills and the requester stops asking for data, the burst would otherwise stay open and the flash would stay selected. The block counts clock cycles while the FIFO stays full. If no new read request arrives before a programmable number of cycles has passed, it pulses a release output that tells the sequencer to deassert chip select. It also sets a sticky timeout flag.

The timeout flag stays set until software clears it with a strobe. An interrupt output follows the flag when the interrupt enable is high. When the counter is disabled the block never releases chip select, however long the FIFO stays full. After a release, the next read request starts a new burst and a new full episode. The prefetch FIFO and the serial sequencer sit outside this block.

Top module: `cs_idle_timeout`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, cs_release_o, tmo_flag_o and irq_o are all low.
- R2: With the counter enabled and tmo_period_i = P, cs_release_o is high for exactly one cycle. That cycle follows the clock edge at which fifo_full_i has been sampled high, with rd_req_i low, on P+1 consecutive edges.
- R3: An edge at which fifo_full_i is low, or rd_req_i is high, restarts the count, so a release needs P+1 fresh qualifying edges after it.
- R4: With tmo_en_i low at an edge, that edge counts nothing and clears the count, so chip select is never released while the counter stays disabled.
- R5: A period of zero gives a release right after the first edge at which the FIFO is sampled full.
- R6: Only one release occurs per full episode. A new release needs the FIFO to stop being full, or a read request, first.
- R7: tmo_flag_o is set at the same edge that raises cs_release_o. It then stays high until an edge samples flag_clr_i high. If a clear and an expiry fall on the same edge, the flag ends up set.
- R8: irq_o is high exactly when tmo_flag_o is high and irq_en_i is high.
- R9: The full 16-bit period range works: a period of 65535 releases after 65536 qualifying edges.
- R10: A read request sampled at the edge where the count would expire suppresses the release for that episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_full_i | input | 1 | Prefetch FIFO is full |
| rd_req_i | input | 1 | New read request strobe from the requester |
| tmo_en_i | input | 1 | Enables the idle counter |
| tmo_period_i | input | 16 | Timeout period in clock cycles |
| irq_en_i | input | 1 | Interrupt enable for the timeout flag |
| flag_clr_i | input | 1 | Clears the timeout flag |
| cs_release_o | output | 1 | One-cycle pulse that requests chip-select release |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Timeout interrupt |

## Verification
Two pairs of events can land on the same edge. In the first, software clears the flag at the same edge as an expiry. The bench raises flag_clr_i so that it is sampled exactly on the (P+1)-th full edge, and expects the flag to remain set. In the second, a read request arrives at the edge of expiry. The bench places rd_req_i on that same edge and expects no release pulse and an unchanged flag. Both cases are judged by a behavioural run-length model that is compared with all three outputs on every cycle.

// File: rtl/cs_idle_timeout_pkg.sv
package cs_idle_timeout_pkg;
    localparam int TMO_W = 16;

    typedef struct packed {
        logic [TMO_W-1:0] count;
        logic             fired;
        logic             release_p;
    } idle_state_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;
endpackage

// File: rtl/cs_idle_counter.sv
module cs_idle_counter
    import cs_idle_timeout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_full_i,
    input  logic             rd_req_i,
    input  logic             en_i,
    input  logic [TMO_W-1:0] period_i,
    output logic             expire_o
);
    idle_state_t st_q, st_d;

    always_comb begin
        st_d           = st_q;
        st_d.release_p = 1'b0;
        if (!fifo_full_i || rd_req_i) begin
            // episode ends or burst restarts
            st_d.count = '0;
            st_d.fired = 1'b0;
        end else if (!en_i) begin
            st_d.count = '0;
        end else if (!st_q.fired) begin
            if (st_q.count >= period_i) begin
                st_d.release_p = 1'b1;
                st_d.fired     = 1'b1;
                st_d.count     = '0;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire_o = st_q.release_p;

    // R3: a non-full edge leaves the count at zero
    p_count_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fifo_full_i) |-> (st_q.count == '0));
    // R4: no release right after a disabled edge
    p_no_release_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !expire_o);
    // R6: release is a single-cycle pulse
    p_release_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
    // R10: request at an edge suppresses release
    p_no_expire_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req_i) |-> !expire_o);
endmodule

// File: rtl/cs_tmo_flag.sv
module cs_tmo_flag
    import cs_idle_timeout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    flag_state_t fs_q, fs_d;

    always_comb begin
        fs_d = fs_q;
        if (set_i)      fs_d.flag = 1'b1;  // set has priority over clear
        else if (clr_i) fs_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign flag_o = fs_q.flag;
    assign irq_o  = fs_q.flag & irq_en_i;

    // R7: flag holds unless a clear was sampled
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_o) && !$past(clr_i)) |-> flag_o);
    // R7: a sampled set always leaves the flag high
    p_flag_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_i) |-> flag_o);
endmodule

// File: rtl/cs_idle_timeout.sv
module cs_idle_timeout
    import cs_idle_timeout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_full_i,
    input  logic             rd_req_i,
    input  logic             tmo_en_i,
    input  logic [TMO_W-1:0] tmo_period_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    output logic             cs_release_o,
    output logic             tmo_flag_o,
    output logic             irq_o
);
    logic expire_d;
    logic expire_q;

    cs_idle_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_full_i (fifo_full_i),
        .rd_req_i    (rd_req_i),
        .en_i        (tmo_en_i),
        .period_i    (tmo_period_i),
        .expire_o    (expire_q)
    );

    // flag is set from the same decision that drives release
    assign expire_d = expire_q;

    cs_tmo_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (u_cnt.st_d.release_p),
        .clr_i    (flag_clr_i),
        .irq_en_i (irq_en_i),
        .flag_o   (tmo_flag_o),
        .irq_o    (irq_o)
    );

    assign cs_release_o = expire_d;

    // R7: release and flag rise together
    p_release_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_release_o |-> tmo_flag_o);
    // R8: interrupt only from a set flag
    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> tmo_flag_o);
endmodule

// File: tb/cs_idle_timeout_test.sv
module cs_idle_timeout_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fifo_full_i, rd_req_i, tmo_en_i, irq_en_i, flag_clr_i;
    logic [15:0] tmo_period_i;
    logic        cs_release_o, tmo_flag_o, irq_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    // reference model state
    int run = 0;
    bit fired = 0;
    bit e_rel = 0;
    bit e_flag = 0;
    bit rel_now;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_idle_timeout uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_full_i  (fifo_full_i),
        .rd_req_i     (rd_req_i),
        .tmo_en_i     (tmo_en_i),
        .tmo_period_i (tmo_period_i),
        .irq_en_i     (irq_en_i),
        .flag_clr_i   (flag_clr_i),
        .cs_release_o (cs_release_o),
        .tmo_flag_o   (tmo_flag_o),
        .irq_o        (irq_o)
    );

    // behavioural run-length model
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            run = 0; fired = 0; e_rel = 0; e_flag = 0;
        end else begin
            rel_now = 0;
            if (!fifo_full_i || rd_req_i) begin
                run = 0; fired = 0;
            end else if (!tmo_en_i) begin
                run = 0;
            end else if (!fired) begin
                run++;
                if (run == int'(tmo_period_i) + 1) begin
                    rel_now = 1; fired = 1; run = 0;
                end
            end
            e_rel = rel_now;
            if (rel_now) e_flag = 1;
            else if (flag_clr_i) e_flag = 0;
        end
    end

    task automatic check1(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check1(cur_req, cs_release_o, e_rel, "cs_release_o");
            check1(cur_req, tmo_flag_o, e_flag, "tmo_flag_o");
            check1(cur_req, irq_o, e_flag & irq_en_i, "irq_o");
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic leave_full();
        fifo_full_i = 0; tick(2);
    endtask

    initial begin
        rst_n = 0; fifo_full_i = 0; rd_req_i = 0; tmo_en_i = 0;
        tmo_period_i = 16'd3; irq_en_i = 0; flag_clr_i = 0;
        tick(3);
        // R1: outputs low during and just after reset
        cur_req = "R1";
        check1("R1", cs_release_o, 1'b0, "reset release");
        check1("R1", tmo_flag_o, 1'b0, "reset flag");
        rst_n = 1; tick(2);

        // R2: basic expiry with period 3
        cur_req = "R2"; tmo_en_i = 1; fifo_full_i = 1; tick(10);
        // R6: stays full long, only one release
        cur_req = "R6"; tick(20); leave_full();
        // R8: interrupt follows flag and enable
        cur_req = "R8"; irq_en_i = 1; tick(3); irq_en_i = 0; tick(2);
        irq_en_i = 1; flag_clr_i = 1; tick(1); flag_clr_i = 0; tick(2);

        // R3: interruptions restart the count
        cur_req = "R3"; fifo_full_i = 1; tick(3); fifo_full_i = 0; tick(1);
        fifo_full_i = 1; tick(2); rd_req_i = 1; tick(1); rd_req_i = 0; tick(8);
        leave_full();

        // R4: disabled counter never releases
        cur_req = "R4"; flag_clr_i = 1; tick(1); flag_clr_i = 0;
        tmo_en_i = 0; fifo_full_i = 1; tick(40);
        tmo_en_i = 1; tick(2); tmo_en_i = 0; tick(1); tmo_en_i = 1; tick(8);
        leave_full();

        // R5: period zero
        cur_req = "R5"; tmo_period_i = 0; flag_clr_i = 1; tick(1); flag_clr_i = 0;
        fifo_full_i = 1; tick(4);
        // R6: a read request restarts the burst and allows a new release
        cur_req = "R6"; rd_req_i = 1; tick(1); rd_req_i = 0; tick(4); leave_full();

        // R7: clear on the same edge as expiry, set wins
        cur_req = "R7"; tmo_period_i = 3; fifo_full_i = 1; flag_clr_i = 1; tick(3);
        tick(1); flag_clr_i = 0; tick(3);
        flag_clr_i = 1; tick(1); flag_clr_i = 0; tick(2); leave_full();
        // exact coincidence: full sampled at 4 edges, clear sampled on the 4th
        fifo_full_i = 1; tick(3); flag_clr_i = 1; tick(1); flag_clr_i = 0; tick(3);
        leave_full();

        // R10: read request at the expiry edge
        cur_req = "R10"; flag_clr_i = 1; tick(1); flag_clr_i = 0;
        fifo_full_i = 1; tick(3); rd_req_i = 1; tick(1); rd_req_i = 0; tick(2);
        leave_full();

        // R9: maximum period
        cur_req = "R9"; tmo_period_i = 16'hFFFF; fifo_full_i = 1; tick(65540);
        leave_full();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired during %s", cur_req);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule